// File: doc/BRIEF.md
# SPI Opcode Refuse/Ignore Filter

This block screens the command byte of each SPI transaction before it reaches a slave's command decoder. Bytes arrive from the deserializer on a valid/ready stream, and transactions are delimited by a one-cycle end pulse that marks chip-select release. The first byte accepted after reset or after an end pulse is the opcode. It is looked up in two programmable lists. A hit in the refuse list rejects the transaction with an invalid-opcode status. A hit in the ignore list discards the transaction but reports success. Any other opcode is forwarded to the decoder, followed by the rest of the transaction's bytes.

The stream rules are these. A byte moves on a cycle where valid and ready are both high. The upstream side must hold `s_valid` and `s_data` until the byte is taken. The filter stalls the upstream side for one cycle while it looks up an opcode. For a forwarded transaction it passes back-pressure from `m_ready` straight to `s_ready`. For a discarded transaction it accepts and drops every byte. `s_ready` is low in any cycle where `cs_end` is high.

Both lists are loaded through a single-cycle write port. Each list has its own valid length, and an entry takes part in the lookup only while its index is below that length.

Top module: `spi_opcode_filter`

## Requirements
- R1: After reset both list lengths are 0, `s_ready` is 1, and `m_valid`, `verdict_valid` and `stat_valid` are 0.
- R2: A cycle with `cfg_we`=1 writes list `cfg_list` (0 = refuse, 1 = ignore). If `cfg_len`=0 it writes entry `cfg_addr` with `cfg_wdata[7:0]`. If `cfg_len`=1 it sets that list's length to `cfg_wdata` (0 to 256). Each list holds 256 entries, and entry 255 is reachable when the length is 256.
- R3: Only the first byte of a transaction is looked up. Later bytes are never compared, even when they equal a listed opcode.
- R4: An opcode present in both lists is refused.
- R5: A refused opcode is not forwarded, nor is any later byte of its transaction, and the transaction's status code is 2.
- R6: An ignored opcode is not forwarded, nor is any later byte of its transaction, and the status code is 1.
- R7: An opcode in neither list is forwarded, followed by the later bytes in order, with status code 0. While `m_ready` is low, the held byte stays on `m_data` with `m_valid` high.
- R8: An end pulse with no byte accepted since the previous end or reset gives status code 3 (no command).
- R9: `verdict_valid` rises, with `verdict_code` holding the lookup result, in the cycle after the opcode is accepted. No other byte is accepted between the opcode and the verdict.
- R10: Entries at indices at or above a list's length never match, and a length of 0 disables the list.
- R11: `stat_valid` pulses for one cycle, with `stat_code`, in the cycle after `cs_end`, and the next accepted byte is treated as a new opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | List write strobe |
| cfg_list | input | 1 | Target list: 0 refuse, 1 ignore |
| cfg_len | input | 1 | 1 writes the length, 0 writes an entry |
| cfg_addr | input | 8 | Entry index |
| cfg_wdata | input | 9 | Entry value (bits 7:0) or length |
| s_valid | input | 1 | Incoming byte valid |
| s_ready | output | 1 | Incoming byte accepted |
| s_data | input | 8 | Incoming byte |
| cs_end | input | 1 | End-of-transaction pulse |
| m_valid | output | 1 | Byte to decoder valid |
| m_ready | input | 1 | Decoder ready |
| m_data | output | 8 | Byte to decoder |
| verdict_valid | output | 1 | Lookup result available for the current transaction |
| verdict_code | output | 2 | 0 pass, 1 ignored, 2 refused |
| stat_valid | output | 1 | One-cycle status pulse after `cs_end` |
| stat_code | output | 2 | 0 pass, 1 ignored, 2 refused, 3 empty |

## Verification
The bench uses an opcode that sits in both lists. A design that checks the ignore list first would report success for it. It also uses an entry stored just past a list's length, and a list whose length has been cleared to zero. A design that ignores the length would wrongly refuse those opcodes. A forwarded transaction carries a refused opcode as its second byte, so a filter that compares every byte would swallow it. The bench also covers an empty transaction, stalls the decoder while the opcode is held, and checks the verdict in the exact cycle after capture, which catches an extra pipeline stage or a missing stall.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [1:0] {
    VC_PASS   = 2'd0,
    VC_IGNORE = 2'd1,
    VC_DENY   = 2'd2,
    VC_EMPTY  = 2'd3
  } vcode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_FWD,
    S_PASS,
    S_DROP
  } fstate_e;
endpackage

// File: rtl/opf_list.sv
module opf_list #(
  parameter int DEPTH = 256,
  parameter int OW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          len_wr,
  input  logic [AW-1:0] wr_addr,
  input  logic [LW-1:0] wr_data,
  input  logic [OW-1:0] key,
  output logic          hit
);
  logic [OW-1:0] ent [DEPTH];
  logic [LW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (wr_en && !len_wr) ent[wr_addr] <= wr_data[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                len_q <= '0;
    else if (wr_en && len_wr)  len_q <= wr_data;
  end

  // Entries past the valid length are masked out of the match.
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((LW'(i) < len_q) && (ent[i] == key)) hit = 1'b1;
    end
  end

  p_len_zero_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && len_wr && wr_data == '0) |=> !hit);
  p_empty_never_hits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (len_q != '0));
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [OW-1:0] s_data,
  input  logic          cs_end,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [OW-1:0] m_data,
  input  logic          deny_hit,
  input  logic          ign_hit,
  output logic [OW-1:0] opc_q,
  output logic          verdict_valid,
  output vcode_e        verdict_code,
  output logic          stat_valid,
  output vcode_e        stat_code
);
  fstate_e state;
  vcode_e  verdict_q, code_now, stat_next;

  // Refuse list wins over ignore list.
  always_comb begin
    if (deny_hit)     code_now = VC_DENY;
    else if (ign_hit) code_now = VC_IGNORE;
    else              code_now = VC_PASS;
  end

  always_comb begin
    if (state == S_IDLE)      stat_next = VC_EMPTY;
    else if (state == S_LOOK) stat_next = code_now;
    else                      stat_next = verdict_q;
  end

  always_comb begin
    s_ready = !cs_end && ((state == S_IDLE) || (state == S_DROP) ||
                          ((state == S_PASS) && m_ready));
    m_valid = (state == S_FWD) || ((state == S_PASS) && s_valid && !cs_end);
    m_data  = (state == S_FWD) ? opc_q : s_data;
  end

  assign verdict_valid = (state == S_FWD) || (state == S_PASS) || (state == S_DROP);
  assign verdict_code  = verdict_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      opc_q      <= '0;
      verdict_q  <= VC_PASS;
      stat_valid <= 1'b0;
      stat_code  <= VC_PASS;
    end else begin
      stat_valid <= 1'b0;
      if (cs_end) begin
        stat_valid <= 1'b1;
        stat_code  <= stat_next;
        state      <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (s_valid) begin
            opc_q <= s_data;
            state <= S_LOOK;
          end
          S_LOOK: begin
            verdict_q <= code_now;
            state     <= (code_now == VC_PASS) ? S_FWD : S_DROP;
          end
          S_FWD: if (m_ready) state <= S_PASS;
          default: ;
        endcase
      end
    end
  end

  p_deny_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOOK && !cs_end && deny_hit) |=> (verdict_valid && verdict_code == VC_DENY));
  p_verdict_next_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && s_valid && s_ready) ##1 !cs_end |=> verdict_valid);
  p_stall_on_lookup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && s_valid && s_ready) |=> !s_ready);
  p_only_pass_forwards_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (verdict_valid && verdict_code == VC_PASS));
  p_empty_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && state == S_IDLE) |=> (stat_valid && stat_code == VC_EMPTY));
  p_status_after_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(cs_end));
  p_hold_under_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FWD && !m_ready && !cs_end) |=> (m_valid && $stable(m_data)));
endmodule

// File: rtl/spi_opcode_filter.sv
module spi_opcode_filter
  import opf_pkg::*;
#(
  parameter int OPC_W      = 8,
  parameter int LIST_DEPTH = 256,
  localparam int IDX_W     = $clog2(LIST_DEPTH),
  localparam int LEN_W     = $clog2(LIST_DEPTH + 1),
  localparam int N_LISTS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_list,
  input  logic             cfg_len,
  input  logic [IDX_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0] cfg_wdata,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [OPC_W-1:0] s_data,
  input  logic             cs_end,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [OPC_W-1:0] m_data,
  output logic             verdict_valid,
  output logic [1:0]       verdict_code,
  output logic             stat_valid,
  output logic [1:0]       stat_code
);
  logic [N_LISTS-1:0] hits;
  logic [OPC_W-1:0]   opc_q;
  vcode_e             vcode, scode;

  // List 0 refuses, list 1 ignores.
  for (genvar g = 0; g < N_LISTS; g++) begin : g_list
    opf_list #(.DEPTH(LIST_DEPTH), .OW(OPC_W)) u_list (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (cfg_list == 1'(g))),
      .len_wr  (cfg_len),
      .wr_addr (cfg_addr),
      .wr_data (cfg_wdata),
      .key     (opc_q),
      .hit     (hits[g])
    );
  end

  opf_ctrl #(.OW(OPC_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .s_valid       (s_valid),
    .s_ready       (s_ready),
    .s_data        (s_data),
    .cs_end        (cs_end),
    .m_valid       (m_valid),
    .m_ready       (m_ready),
    .m_data        (m_data),
    .deny_hit      (hits[0]),
    .ign_hit       (hits[1]),
    .opc_q         (opc_q),
    .verdict_valid (verdict_valid),
    .verdict_code  (vcode),
    .stat_valid    (stat_valid),
    .stat_code     (scode)
  );

  assign verdict_code = vcode;
  assign stat_code    = scode;
endmodule

// File: tb/spi_opcode_filter_tb.sv
module spi_opcode_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_list = 1'b0, cfg_len = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [8:0] cfg_wdata = '0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic cs_end = 1'b0;
  logic m_ready = 1'b1;
  logic s_ready, m_valid, verdict_valid, stat_valid;
  logic [7:0] m_data;
  logic [1:0] verdict_code, stat_code;

  int n_chk = 0, n_fail = 0;
  int fcnt = 0;
  logic [7:0] fwd [8];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_opcode_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_list(cfg_list), .cfg_len(cfg_len),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .cs_end(cs_end), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .verdict_valid(verdict_valid), .verdict_code(verdict_code),
    .stat_valid(stat_valid), .stat_code(stat_code)
  );

  always @(posedge clk) begin
    if (m_valid && m_ready) begin
      if (fcnt < 8) fwd[fcnt] = m_data;
      fcnt = fcnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic lst, input logic is_len, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_list = lst; cfg_len = is_len; cfg_addr = 8'(addr); cfg_wdata = 9'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic hs;
    s_valid = 1; s_data = b; hs = 0;
    while (!hs) begin
      #1 hs = s_ready;
      @(posedge clk);
      if (!hs) @(negedge clk);
    end
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic end_txn(input int exp, input string req);
    cs_end = 1;
    @(negedge clk);
    cs_end = 0;
    check(stat_valid == 1'b1, "R11", stat_valid, 1);
    check(stat_code == 2'(exp), req, stat_code, exp);
    @(negedge clk);
    check(stat_valid == 1'b0, "R11", stat_valid, 0);
  endtask

  // Opcode, then the refuse opcode 0x06 and 0x55 as trailing bytes.
  task automatic run_txn(input logic [7:0] opc, input int exp);
    string tag;
    tag = (exp == 0) ? "R7" : (exp == 1) ? "R6" : "R5";
    fcnt = 0;
    send_byte(opc);
    check(verdict_valid == 1'b0, "R9", verdict_valid, 0);
    @(negedge clk);
    check(verdict_valid == 1'b1, "R9", verdict_valid, 1);
    check(verdict_code == 2'(exp), tag, verdict_code, exp);
    send_byte(8'h06);
    send_byte(8'h55);
    @(negedge clk);
    end_txn(exp, tag);
    if (exp == 0) begin
      check(fcnt == 3, tag, fcnt, 3);
      check(fwd[0] == opc, tag, fwd[0], opc);
      check(fwd[1] == 8'h06, "R3", fwd[1], 8'h06);
      check(fwd[2] == 8'h55, tag, fwd[2], 8'h55);
    end else begin
      check(fcnt == 0, tag, fcnt, 0);
    end
  endtask

  // {opcode, expected code}
  localparam logic [9:0] VEC [7] = '{
    {8'h06, 2'd2},  // R5 refused
    {8'h20, 2'd2},  // R4 in both lists
    {8'h05, 2'd1},  // R6 ignored
    {8'hAB, 2'd1},  // R6 ignored, last valid ignore entry
    {8'h9F, 2'd0},  // R10 stored past refuse length
    {8'h03, 2'd0},  // R7 in neither list
    {8'hC7, 2'd2}   // R5 last valid refuse entry
  };

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check(s_ready == 1'b1, "R1", s_ready, 1);
    check(m_valid == 1'b0, "R1", m_valid, 0);
    check(verdict_valid == 1'b0, "R1", verdict_valid, 0);
    check(stat_valid == 1'b0, "R1", stat_valid, 0);

    // R10 lengths are 0 after reset, so an unwritten opcode passes
    run_txn(8'h00, 0);

    // R8 empty transaction
    @(negedge clk);
    end_txn(3, "R8");

    // R2 load lists
    cfg_write(0, 0, 0, 8'h06); cfg_write(0, 0, 1, 8'h20);
    cfg_write(0, 0, 2, 8'hC7); cfg_write(0, 0, 3, 8'h9F);
    cfg_write(0, 1, 0, 3);
    cfg_write(1, 0, 0, 8'h20); cfg_write(1, 0, 1, 8'h05);
    cfg_write(1, 0, 2, 8'hAB);
    cfg_write(1, 1, 0, 3);

    for (int i = 0; i < 7; i++) run_txn(VEC[i][9:2], int'(VEC[i][1:0]));

    // R7 back-pressure: opcode held while the decoder stalls
    fcnt = 0;
    m_ready = 0;
    send_byte(8'h03);
    @(negedge clk);
    check(m_valid == 1'b1 && m_data == 8'h03, "R7", m_data, 8'h03);
    @(negedge clk);
    check(m_valid == 1'b1 && m_data == 8'h03, "R7", m_data, 8'h03);
    check(fcnt == 0, "R7", fcnt, 0);
    m_ready = 1;
    @(negedge clk);
    check(fcnt == 1, "R7", fcnt, 1);
    end_txn(0, "R7");

    // R10 clearing the refuse length disables that list
    cfg_write(0, 1, 0, 0);
    run_txn(8'h06, 0);
    run_txn(8'h20, 1);  // still in the ignore list

    // R2 full capacity: entry 255 active at length 256
    cfg_write(1, 0, 255, 8'h35);
    cfg_write(1, 1, 0, 256);
    run_txn(8'h35, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule